// File: doc/BRIEF.md
# Adaptive Hall Position Deglitch Filter

This block sits behind the three Hall comparators of a brushless motor controller. It takes the three Hall bits, which are already synchronized to the clock, and turns them into a sector number. It passes a new sector to its output only after the sector has been held for a filter time. The filter time follows the rotation speed. From reset, or after a stall, it sits at a quarter of the stall limit. The second valid commutation sets it to a quarter of the interval between the first two commutations. Once two rising edges of the filtered U phase have been seen, it is a fraction of the time between them, which is one electrical period.

The block also produces four other signals:
- a one-cycle zero-crossing pulse on every filtered U rise;
- a speed signal that toggles on every filtered U edge;
- a direction-match flag that compares each commutation step against the requested direction;
- a one-cycle start request, raised when no commutation arrives within the stall limit.

When the drive is released from free run, the block emits a zero-crossing pulse by default. It also clears the direction-match flag until a commutation confirms the direction.

Top module: `hall_deglitch`

## Requirements
- R1: The Hall code {hall_u,hall_v,hall_w} maps to a sector as follows: 100 is 0, 110 is 1, 010 is 2, 011 is 3, 001 is 4 and 101 is 5. The codes 000 and 111 are invalid and read as 7. After reset, `pos_filt` is 7.
- R2: A new Hall code reaches `pos_filt` only after it has been held unchanged at the input for `filt_time`+2 rising clock edges. A code held for fewer edges, followed by a return to the filtered code, leaves `pos_filt` unchanged.
- R3: During and after reset, `filt_time` equals EL_SAT>>2, which is 500 with the defaults.
- R4: A commutation is a filtered change between two valid sectors. The second commutation after reset or after a stall sets `filt_time` to a quarter of the clock edges between the first two commutations. Later commutations leave it unchanged until the first zero-crossing.
- R5: If EL_SAT clock edges pass without a commutation, `start_req` pulses high for one cycle and `filt_time` returns to EL_SAT>>2.
- R6: `zc_pulse` is high for one cycle when the filtered U bit rises between two valid sectors. From the second such rise on, `filt_time` becomes the edge count between the last two rises shifted right by 5.
- R7: `fg` toggles on every change of the filtered U bit between two valid sectors. Changes into or out of an invalid code toggle neither `fg` nor `zc_pulse`.
- R8: `dm` is high during and after reset. On each commutation it becomes 1 if the step matches the requested direction and 0 otherwise. With `dir_fwd`=1 the matching step is sector+1 mod 6; with `dir_fwd`=0 it is sector−1 mod 6.
- R9: A rising edge on `run_en` gives a `zc_pulse` and a low `dm` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; direction cannot be detected while high |
| hall_u | input | 1 | Synchronized Hall U comparator bit |
| hall_v | input | 1 | Synchronized Hall V comparator bit |
| hall_w | input | 1 | Synchronized Hall W comparator bit |
| dir_fwd | input | 1 | Requested direction, 1 = forward |
| run_en | input | 1 | Free-run release, rising edge starts driving |
| pos_filt | output | 3 | Filtered sector 0..5, 7 = invalid |
| zc_pulse | output | 1 | One-cycle zero-crossing pulse |
| fg | output | 1 | Speed signal, toggles on filtered U edges |
| dm | output | 1 | Detected direction matches the requested one |
| start_req | output | 1 | One-cycle pulse when the stall limit is reached |
| filt_time | output | CNT_W | Current filter time in clock edges |

## Verification
The assertions assume that the Hall bits and `run_en` are synchronous to the clock. They also assume that `filt_time` never exceeds the range of the hold counter, which holds because the counter saturates. The bench drives every input on the falling edge. It holds each Hall code for a fixed number of edges longer than the current filter time, or deliberately a single edge short of it. Each sector hold is kept below the stall limit, except in the one scenario that tests the stall.

// File: rtl/hall_deglitch.sv
module hall_deglitch #(
  parameter int CNT_W      = 12,
  parameter int EL_SAT     = 2000,
  parameter int HALL_SHIFT = 2,
  parameter int ZC_SHIFT   = 5,
  parameter int ZC_W       = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hall_u,
  input  logic             hall_v,
  input  logic             hall_w,
  input  logic             dir_fwd,
  input  logic             run_en,
  output logic [2:0]       pos_filt,
  output logic             zc_pulse,
  output logic             fg,
  output logic             dm,
  output logic             start_req,
  output logic [CNT_W-1:0] filt_time
);

  localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(EL_SAT);
  localparam logic [CNT_W-1:0] SAT_M1  = CNT_W'(EL_SAT - 1);
  localparam logic [CNT_W-1:0] FT_INIT = CNT_W'(EL_SAT >> HALL_SHIFT);
  localparam logic [2:0]       BAD     = 3'd7;

  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_HALL, PH_ZC} phase_t;

  function automatic logic [2:0] to_sector(input logic [2:0] c);
    case (c)
      3'b100:  to_sector = 3'd0;
      3'b110:  to_sector = 3'd1;
      3'b010:  to_sector = 3'd2;
      3'b011:  to_sector = 3'd3;
      3'b001:  to_sector = 3'd4;
      3'b101:  to_sector = 3'd5;
      default: to_sector = BAD;
    endcase
  endfunction

  logic [2:0]       filt_q, prev_q;
  logic [CNT_W-1:0] cnt_q, ftime_q, el_c_q;
  logic [ZC_W-1:0]  el_z_q;
  phase_t           phase_q;
  logic             zc_q, fg_q, dm_q, start_q, run_q;

  logic [2:0]      raw, raw_sec, filt_sec, sec_next, sec_prev;
  logic            diff, fresh, take, comm, u_rise, u_edge, matched, rel, stall;
  logic [ZC_W-1:0] zc_div;

  assign raw      = {hall_u, hall_v, hall_w};
  assign raw_sec  = to_sector(raw);
  assign filt_sec = to_sector(filt_q);
  assign sec_next = (filt_sec == 3'd5) ? 3'd0 : filt_sec + 3'd1;
  assign sec_prev = (filt_sec == 3'd0) ? 3'd5 : filt_sec - 3'd1;

  assign diff    = raw != filt_q;
  assign fresh   = raw != prev_q;
  assign take    = diff && !fresh && (cnt_q >= ftime_q);
  assign comm    = take && (raw_sec != BAD) && (filt_sec != BAD);
  assign u_edge  = comm && (raw[2] != filt_q[2]);
  assign u_rise  = u_edge && raw[2];
  assign matched = dir_fwd ? (raw_sec == sec_next) : (raw_sec == sec_prev);
  assign rel     = run_en && !run_q;
  assign stall   = !comm && (el_c_q == SAT_M1);
  assign zc_div  = el_z_q >> ZC_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q  <= 3'b000;
      prev_q  <= 3'b000;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      zc_q    <= 1'b0;
      fg_q    <= 1'b0;
      dm_q    <= 1'b1;
    end else begin
      prev_q <= raw;
      run_q  <= run_en;
      if (!diff || fresh || take) cnt_q <= '0;
      else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
      if (take) filt_q <= raw;
      zc_q <= rel || u_rise;
      if (u_edge) fg_q <= !fg_q;
      if (rel)       dm_q <= 1'b0;
      else if (comm) dm_q <= matched;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      el_c_q  <= '0;
      el_z_q  <= '0;
      ftime_q <= FT_INIT;
      phase_q <= PH_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (comm)                el_c_q <= CNT_W'(1);
      else if (el_c_q != SAT_C) el_c_q <= el_c_q + 1'b1;
      if (u_rise)              el_z_q <= ZC_W'(1);
      else if (el_z_q != '1)   el_z_q <= el_z_q + 1'b1;
      if (stall) begin
        start_q <= 1'b1;
        phase_q <= PH_IDLE;
        ftime_q <= FT_INIT;
      end else begin
        case (phase_q)
          PH_IDLE:  if (comm) phase_q <= PH_FIRST;
          PH_FIRST: if (comm) begin
                      ftime_q <= el_c_q >> HALL_SHIFT;
                      phase_q <= PH_HALL;
                    end
          PH_HALL:  if (u_rise) phase_q <= PH_ZC;
          default:  if (u_rise) ftime_q <= zc_div[CNT_W-1:0];
        endcase
      end
    end
  end

  assign pos_filt  = filt_sec;
  assign zc_pulse  = zc_q;
  assign fg        = fg_q;
  assign dm        = dm_q;
  assign start_req = start_q;
  assign filt_time = ftime_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> $past(cnt_q >= ftime_q));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  assert_el_sat_R5: assert property (@(posedge clk) disable iff (rst)
    el_c_q <= SAT_C);

  assert_fg_follows_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(fg_q) |-> !$stable(filt_q));

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |=> (zc_q && !dm_q));

endmodule

// File: tb/tb_hall_deglitch.sv
`timescale 1ns/1ps
module tb_hall_deglitch;
  logic clk = 1'b0;
  logic rst, hall_u, hall_v, hall_w, dir_fwd, run_en;
  logic [2:0]  pos_filt;
  logic        zc_pulse, fg, dm, start_req;
  logic [11:0] filt_time;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hall_deglitch dut (
    .clk(clk), .rst(rst), .hall_u(hall_u), .hall_v(hall_v), .hall_w(hall_w),
    .dir_fwd(dir_fwd), .run_en(run_en), .pos_filt(pos_filt), .zc_pulse(zc_pulse),
    .fg(fg), .dm(dm), .start_req(start_req), .filt_time(filt_time)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_code(input logic [2:0] c);
    {hall_u, hall_v, hall_w} = c;
  endtask

  task automatic put(input int s);
    case (s)
      0: put_code(3'b100);
      1: put_code(3'b110);
      2: put_code(3'b010);
      3: put_code(3'b011);
      4: put_code(3'b001);
      default: put_code(3'b101);
    endcase
  endtask

  task automatic t_reset;
    rst = 1'b1; dir_fwd = 1'b1; run_en = 1'b0; put(0);
    repeat (3) @(negedge clk);
    chk("R1 reset pos", pos_filt, 7);
    chk("R8 reset dm", dm, 1);
    chk("R7 reset fg", fg, 0);
    chk("R6 reset zc", zc_pulse, 0);
    chk("R5 reset start", start_req, 0);
    chk("R3 reset filter time", filt_time, 500);
  endtask

  task automatic t_acquire;
    rst = 1'b0;
    step(501);
    chk("R2 code not yet accepted", pos_filt, 7);
    step(1);
    chk("R1 sector 0 accepted", pos_filt, 0);
  endtask

  task automatic t_glitch;
    put(1);
    step(501);
    chk("R2 short pulse rejected", pos_filt, 0);
    put(0);
    step(2);
    chk("R2 position held after glitch", pos_filt, 0);
  endtask

  task automatic t_forward;
    put(1); step(600);
    chk("R1 sector 1", pos_filt, 1);
    chk("R8 forward match", dm, 1);
    chk("R3 filter time before second commutation", filt_time, 500);
    put(2); step(600);
    chk("R1 sector 2", pos_filt, 2);
    chk("R4 filter time from hall interval", filt_time, 150);
    chk("R7 fg toggles on U fall", fg, 1);
    put(3); step(600);
    chk("R4 filter time kept in hall phase", filt_time, 150);
    put(4); step(600);
    chk("R1 sector 4", pos_filt, 4);
    put(5); step(151);
    chk("R6 no zc before acceptance", zc_pulse, 0);
    step(1);
    chk("R6 zc on U rise", zc_pulse, 1);
    step(1);
    chk("R6 zc one cycle", zc_pulse, 0);
    chk("R7 fg toggles on U rise", fg, 0);
    step(447);
    for (int s = 0; s < 5; s++) begin
      put(s); step(600);
    end
    put(5); step(152);
    chk("R6 second zc", zc_pulse, 1);
    step(448);
    chk("R6 filter time from zc interval", filt_time, 112);
    chk("R8 forward match kept", dm, 1);
  endtask

  task automatic t_stall;
    put(0); step(114);
    chk("R1 sector 0 after lap", pos_filt, 0);
    step(1998);
    chk("R5 no start before limit", start_req, 0);
    step(1);
    chk("R5 start request at limit", start_req, 1);
    chk("R5 filter time restored", filt_time, 500);
    step(1);
    chk("R5 start request one cycle", start_req, 0);
  endtask

  task automatic t_direction;
    dir_fwd = 1'b0;
    put(5); step(600);
    chk("R1 sector 5", pos_filt, 5);
    chk("R8 backward step matches", dm, 1);
    put(0); step(600);
    chk("R8 forward step mismatches", dm, 0);
    put(5); step(600);
    chk("R8 backward step matches again", dm, 1);
    chk("R4 filter time after restart", filt_time, 150);
  endtask

  task automatic t_release;
    run_en = 1'b1;
    step(1);
    chk("R9 release zc", zc_pulse, 1);
    chk("R9 release clears dm", dm, 0);
    step(1);
    chk("R9 release zc one cycle", zc_pulse, 0);
    put(4); step(152);
    chk("R8 dm confirmed after release", dm, 1);
    chk("R1 sector 4 backward", pos_filt, 4);
    step(448);
  endtask

  task automatic t_invalid;
    int f0;
    f0 = fg;
    put_code(3'b111); step(502);
    chk("R7 no zc into invalid", zc_pulse, 0);
    step(98);
    chk("R1 invalid code reads 7", pos_filt, 7);
    chk("R7 fg unchanged into invalid", fg, f0);
    chk("R8 dm unchanged by invalid", dm, 1);
    put(4); step(600);
    chk("R1 valid again", pos_filt, 4);
    chk("R7 fg unchanged out of invalid", fg, f0);
  endtask

  task automatic t_reset_mid;
    rst = 1'b1; step(1);
    chk("R1 pos after mid reset", pos_filt, 7);
    chk("R8 dm after mid reset", dm, 1);
    chk("R3 filter time after mid reset", filt_time, 500);
    chk("R7 fg after mid reset", fg, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_acquire();
    t_glitch();
    t_forward();
    t_stall();
    t_direction();
    t_release();
    t_invalid();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule